// File: doc/BRIEF.md
# Soft-Switch Memory Bank Decoder

This block routes every bus access of an 8-bit computer with a 64 KiB address space to exactly one target: base RAM, auxiliary RAM, internal ROM, the IO page, or expansion-card space that is left unmapped so that a plug-in card can answer. The routing depends on the address range and on a set of soft-switch flags. These flags are held elsewhere and arrive here as levels.

Reads and writes in the general RAM area are steered by separate flags. The zero/stack pages follow their own flag. The high 12 KiB follows the language-card state, which a neighbouring block supplies. The block holds one state bit of its own: a latch that claims the C800–CFFF expansion-ROM window for internal ROM. Touching the C3 page while the slot-3 card is not selected sets this latch. An access to CFFF or a reset clears it.

The target select is combinational from the current access and the latch value held before the access ends. For language-card RAM in D000–DFFF, the block also folds the RAM address when the alternate 4 KiB bank is chosen.

Top module: `bank_decoder`

## Requirements
- R1: Addresses 0000–01FF select auxiliary RAM when `zp_aux_i` is 1 and base RAM when it is 0, for reads and for writes.
- R2: A read (`we_i`=0) in 0200–BFFF selects auxiliary RAM when `rd_aux_i` is 1 and base RAM otherwise.
- R3: A write (`we_i`=1) in 0200–BFFF selects auxiliary RAM when `wr_aux_i` is 1 and base RAM otherwise. `rd_aux_i` has no effect on writes.
- R4: C000–C0FF always selects the IO target, whatever the flags are.
- R5: C100–C2FF and C400–C7FF select ROM when `cx_int_i` is 1 and the card target otherwise.
- R6: C300–C3FF selects ROM when `cx_int_i` is 1 or `c3_slot_i` is 0, and the card target otherwise.
- R7: C800–CFFF selects ROM when `cx_int_i` is 1 or the C8 latch is set, and the card target otherwise.
- R8: A valid access to the C3 page while `c3_slot_i` is 0 sets the C8 latch at the rising clock edge on which `valid_i` is high. The access itself is decoded with the latch value from before that edge. When `valid_i` is low, the latch holds its value.
- R9: A valid access to CFFF clears the C8 latch at that edge, and a low `rst_ni` clears it at once. If one access would both set and clear the latch, clearing wins.
- R10: A read in D000–FFFF selects ROM when `lc_rd_ram_i` is 0. When it is 1, the read selects auxiliary RAM if `zp_aux_i` is 1 and base RAM if `zp_aux_i` is 0.
- R11: A write in D000–FFFF selects RAM when `lc_wr_en_i` is 1, with auxiliary or base RAM chosen by `zp_aux_i`. When `lc_wr_en_i` is 0, the write selects the ROM target, which discards it.
- R12: `ram_addr_o` equals `addr_i - 16'h1000` for addresses D000–DFFF while `lc_bank1_i` is 1. For every other address it equals `addr_i`.
- R13: `sel_o` is one-hot with bit 0 = base RAM, bit 1 = auxiliary RAM, bit 2 = ROM, bit 3 = IO, bit 4 = card. When `valid_i` is 1, exactly one bit is set. When `valid_i` is 0, all bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Access address |
| we_i | input | 1 | 1 = write, 0 = read |
| valid_i | input | 1 | Bus access in progress this cycle |
| zp_aux_i | input | 1 | Zero/stack pages and language-card RAM use auxiliary RAM |
| rd_aux_i | input | 1 | Reads of the general area use auxiliary RAM |
| wr_aux_i | input | 1 | Writes of the general area use auxiliary RAM |
| cx_int_i | input | 1 | Whole C100–CFFF area taken by internal ROM |
| c3_slot_i | input | 1 | C3 page given to card 3 instead of ROM |
| lc_rd_ram_i | input | 1 | Language-card reads come from RAM |
| lc_wr_en_i | input | 1 | Language-card RAM accepts writes |
| lc_bank1_i | input | 1 | Alternate 4 KiB bank selected for D000–DFFF |
| sel_o | output | 5 | One-hot target select |
| ram_addr_o | output | 16 | RAM address after the bank fold |

## Verification
`sel_o` and `ram_addr_o` are due in the same cycle as the access, with no register on the path. The bench therefore drives inputs on the falling edge and compares both outputs 1 ns later, before the next rising edge. The C8 latch takes effect one cycle after the access that sets or clears it. The bench's reference model updates its own latch copy only after the rising edge, so the access that touches CFFF or the C3 page is still checked against the old latch value. Reset clears the latch at once, and this is checked by an access made while reset is held low.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;
  localparam int TGT_N  = 5;

  typedef enum logic [2:0] {
    T_BASE = 3'd0,
    T_AUX  = 3'd1,
    T_ROM  = 3'd2,
    T_IO   = 3'd3,
    T_CARD = 3'd4
  } tgt_e;

  typedef enum logic [2:0] {
    RG_ZP,
    RG_MAIN,
    RG_IO,
    RG_CX,
    RG_C3,
    RG_C8,
    RG_LC_BANK,
    RG_LC_HIGH
  } region_e;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output logic          c3_hit_o,
  output logic          cfff_hit_o
);
  logic [PW-1:0] page;
  assign page       = addr_i[AW-1 -: PW];
  assign c3_hit_o   = (page == PW'(8'hC3));
  assign cfff_hit_o = (addr_i == AW'(16'hCFFF));

  always_comb begin
    if (page < PW'(8'h02))      region_o = RG_ZP;
    else if (page < PW'(8'hC0)) region_o = RG_MAIN;
    else if (page == PW'(8'hC0)) region_o = RG_IO;
    else if (c3_hit_o)          region_o = RG_C3;
    else if (page < PW'(8'hC8)) region_o = RG_CX;
    else if (page < PW'(8'hD0)) region_o = RG_C8;
    else if (page < PW'(8'hE0)) region_o = RG_LC_BANK;
    else                        region_o = RG_LC_HIGH;
  end
endmodule

// File: rtl/c8_latch.sv
module c8_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= 1'b0;
    else if (valid_i && clr_i)  q_o <= 1'b0;  // clear has priority
    else if (valid_i && set_i)  q_o <= 1'b1;
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && clr_i |=> !q_o);
  p_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_i && !clr_i |=> q_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(q_o));
endmodule

// File: rtl/target_select.sv
module target_select
  import bank_pkg::*;
#(
  parameter int NT = TGT_N
) (
  input  region_e       region_i,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic          zp_aux_i,
  input  logic          rd_aux_i,
  input  logic          wr_aux_i,
  input  logic          cx_int_i,
  input  logic          c3_slot_i,
  input  logic          c8_own_i,
  input  logic          lc_rd_ram_i,
  input  logic          lc_wr_en_i,
  output logic [NT-1:0] sel_o
);
  tgt_e tgt;
  logic lc_ram;
  tgt_e zp_ram;

  assign lc_ram = we_i ? lc_wr_en_i : lc_rd_ram_i;
  assign zp_ram = zp_aux_i ? T_AUX : T_BASE;

  always_comb begin
    unique case (region_i)
      RG_ZP:      tgt = zp_ram;
      RG_MAIN:    tgt = (we_i ? wr_aux_i : rd_aux_i) ? T_AUX : T_BASE;
      RG_IO:      tgt = T_IO;
      RG_CX:      tgt = cx_int_i ? T_ROM : T_CARD;
      RG_C3:      tgt = (cx_int_i || !c3_slot_i) ? T_ROM : T_CARD;
      RG_C8:      tgt = (cx_int_i || c8_own_i) ? T_ROM : T_CARD;
      RG_LC_BANK,
      RG_LC_HIGH: tgt = lc_ram ? zp_ram : T_ROM;
      default:    tgt = T_BASE;
    endcase
  end

  for (genvar g = 0; g < NT; g++) begin : g_sel
    assign sel_o[g] = valid_i && (tgt == tgt_e'(3'(g)));
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
#(
  parameter int          AW     = ADDR_W,
  parameter int          NT     = TGT_N,
  parameter logic [15:0] LC_OFS = 16'h1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          valid_i,
  input  logic          zp_aux_i,
  input  logic          rd_aux_i,
  input  logic          wr_aux_i,
  input  logic          cx_int_i,
  input  logic          c3_slot_i,
  input  logic          lc_rd_ram_i,
  input  logic          lc_wr_en_i,
  input  logic          lc_bank1_i,
  output logic [NT-1:0] sel_o,
  output logic [AW-1:0] ram_addr_o
);
  region_e region;
  logic    c3_hit, cfff_hit, c8_own;

  region_decode #(.AW(AW), .PW(PAGE_W)) u_region (
    .addr_i    (addr_i),
    .region_o  (region),
    .c3_hit_o  (c3_hit),
    .cfff_hit_o(cfff_hit)
  );

  c8_latch u_c8 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .set_i  (c3_hit && !c3_slot_i),
    .clr_i  (cfff_hit),
    .q_o    (c8_own)
  );

  target_select #(.NT(NT)) u_sel (
    .region_i   (region),
    .valid_i    (valid_i),
    .we_i       (we_i),
    .zp_aux_i   (zp_aux_i),
    .rd_aux_i   (rd_aux_i),
    .wr_aux_i   (wr_aux_i),
    .cx_int_i   (cx_int_i),
    .c3_slot_i  (c3_slot_i),
    .c8_own_i   (c8_own),
    .lc_rd_ram_i(lc_rd_ram_i),
    .lc_wr_en_i (lc_wr_en_i),
    .sel_o      (sel_o)
  );

  // alternate bank lives one 4 KiB step below the window
  assign ram_addr_o = (region == RG_LC_BANK && lc_bank1_i) ? addr_i - AW'(LC_OFS) : addr_i;

  p_one_target_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $countones(sel_o) == 1);
  p_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> sel_o == '0);
  p_io_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i[AW-1 -: PAGE_W] == PAGE_W'(8'hC0) |-> sel_o[T_IO]);
  p_zp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && addr_i < AW'(16'h0200) |-> sel_o[zp_aux_i ? T_AUX : T_BASE]);
endmodule

// File: tb/tb_bank_decoder.sv
`timescale 1ns/1ps
module tb_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0, valid = 1'b0;
  logic        zp_aux = 1'b0, rd_aux = 1'b0, wr_aux = 1'b0;
  logic        cx_int = 1'b0, c3_slot = 1'b0;
  logic        lc_rd = 1'b0, lc_wr = 1'b0, lc_b1 = 1'b0;
  logic [4:0]  sel;
  logic [15:0] ram_addr;

  int errors = 0;
  int checks = 0;
  bit m_latch = 1'b0;

  always #2.5 clk = ~clk;

  bank_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .valid_i(valid),
    .zp_aux_i(zp_aux), .rd_aux_i(rd_aux), .wr_aux_i(wr_aux),
    .cx_int_i(cx_int), .c3_slot_i(c3_slot),
    .lc_rd_ram_i(lc_rd), .lc_wr_en_i(lc_wr), .lc_bank1_i(lc_b1),
    .sel_o(sel), .ram_addr_o(ram_addr)
  );

  // target index: 0 base, 1 aux, 2 rom, 3 io, 4 card
  function automatic int model_tgt(int a, bit w);
    int ram = zp_aux ? 1 : 0;
    if (a < 'h200) return ram;
    if (a < 'hC000) return (w ? wr_aux : rd_aux) ? 1 : 0;
    if (a < 'hC100) return 3;
    if (a >= 'hC300 && a < 'hC400) return (cx_int || !c3_slot) ? 2 : 4;
    if (a < 'hC800) return cx_int ? 2 : 4;
    if (a < 'hD000) return (cx_int || m_latch) ? 2 : 4;
    if (w) return lc_wr ? ram : 2;
    return lc_rd ? ram : 2;
  endfunction

  function automatic string req_of(int a, bit w, bit v);
    if (!v) return "R13";
    if (a < 'h200) return "R1";
    if (a < 'hC000) return w ? "R3" : "R2";
    if (a < 'hC100) return "R4";
    if (a >= 'hC300 && a < 'hC400) return "R6";
    if (a < 'hC800) return "R5";
    if (a < 'hD000) return "R7 R8 R9";
    return w ? "R11" : "R10";
  endfunction

  task automatic check_now();
    logic [4:0]  exp_sel;
    logic [15:0] exp_addr;
    int a = int'(addr);
    exp_sel  = valid ? (5'b1 << model_tgt(a, we)) : 5'b0;
    exp_addr = (a >= 'hD000 && a < 'hE000 && lc_b1) ? 16'(a - 'h1000) : addr;
    checks++;
    if (sel !== exp_sel) begin
      errors++;
      $display("FAIL %s addr=%h we=%0b sel=%b expected %b", req_of(a, we, valid), addr, we, sel, exp_sel);
    end
    checks++;
    if (ram_addr !== exp_addr) begin
      errors++;
      $display("FAIL R12 addr=%h ram_addr=%h expected %h", addr, ram_addr, exp_addr);
    end
  endtask

  // drive at falling edge, check before rising edge, advance model after it
  task automatic acc(input logic [15:0] a, input bit w, input bit v);
    addr = a; we = w; valid = v;
    #1;
    check_now();
    @(posedge clk);
    if (v) begin
      if (a == 16'hCFFF) m_latch = 1'b0;
      else if (a[15:8] == 8'hC3 && !c3_slot) m_latch = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic flags(input bit z, input bit r, input bit wa, input bit cx, input bit s3,
                       input bit lr, input bit lw, input bit b1);
    zp_aux = z; rd_aux = r; wr_aux = wa; cx_int = cx; c3_slot = s3;
    lc_rd = lr; lc_wr = lw; lc_b1 = b1;
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0; m_latch = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // reset state: latch clear, C8 window unmapped (R9)
    valid = 1'b1; addr = 16'hC800; #1; check_now();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    flags(0,1,1,0,1,0,0,0); acc(16'h0100, 0, 1); acc(16'h01FF, 1, 1);
    flags(1,0,0,0,1,0,0,0); acc(16'h0000, 0, 1); acc(16'h0150, 1, 1);
    // R2 R3: separate read/write steering
    flags(0,1,0,0,1,0,0,0); acc(16'h0200, 0, 1); acc(16'h5000, 1, 1);
    flags(0,0,1,0,1,0,0,0); acc(16'hBFFF, 0, 1); acc(16'h0400, 1, 1);
    // R4
    flags(1,1,1,1,0,1,1,1); acc(16'hC000, 0, 1); acc(16'hC0FF, 1, 1);
    // R5
    flags(0,0,0,0,1,0,0,0); acc(16'hC100, 0, 1); acc(16'hC7FF, 0, 1);
    flags(0,0,0,1,1,0,0,0); acc(16'hC2FF, 0, 1); acc(16'hC400, 0, 1);
    // R6, R7 before latch, R8 hold when idle
    flags(0,0,0,0,1,0,0,0); acc(16'hC300, 0, 1); acc(16'hC800, 0, 1);
    flags(0,0,0,0,0,0,0,0); acc(16'hC3AA, 0, 0); acc(16'hC900, 0, 1);
    // R8: set on C3 touch, this access uses old value
    acc(16'hC3FF, 0, 1); acc(16'hCABC, 0, 1);
    flags(0,0,0,0,1,0,0,0); acc(16'hC800, 1, 1);
    // R9: CFFF access sees old latch, then clears
    acc(16'hCFFF, 0, 1); acc(16'hCC00, 0, 1);
    // R9: reset clears
    flags(0,0,0,0,0,0,0,0); acc(16'hC310, 0, 1); acc(16'hCFFE, 0, 1);
    pulse_reset(); acc(16'hC800, 0, 1);
    // R7 with internal ROM flag
    flags(0,0,0,1,1,0,0,0); acc(16'hCFFE, 0, 1);
    // R10 R11 R12
    flags(0,0,0,0,1,0,0,0); acc(16'hD000, 0, 1); acc(16'hE000, 1, 1);
    flags(1,0,0,0,1,1,1,1); acc(16'hD123, 0, 1); acc(16'hDFFF, 1, 1);
    flags(0,0,0,0,1,1,0,1); acc(16'hD800, 1, 1); acc(16'hFFFF, 0, 1);
    flags(0,0,0,0,1,0,1,0); acc(16'hD800, 0, 1); acc(16'hF000, 1, 1);

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      int pick = $urandom_range(0, 15);
      a = 16'($urandom);
      if (pick < 2) a = {8'hC3, a[7:0]};
      else if (pick == 2) a = 16'hCFFF;
      else if (pick < 6) a = {4'hC, a[11:0]};
      else if (pick < 8) a = {4'hD, a[11:0]};
      flags($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            ($urandom_range(0,3) == 0), $urandom_range(0,1),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1));
      acc(a, 1'($urandom_range(0,1)), ($urandom_range(0,7) != 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule